// File: doc/BRIEF.md
# Serial Configuration Bitstream Server

This block is the logic core of a serial configuration memory. A bitstream is held in a byte-wide storage array and sent to a device that is loading its configuration, one bit per rising edge of a clock that the loading device supplies. That external clock and the output-enable input are oversampled by a faster local system clock. The served bit is placed on a data output that has a separate enable, and the output counts as released (high impedance) whenever the enable is low.

On the first power-up after power-good is asserted, a power-on delay must pass before anything is served. After that delay the block is ready for good, until power-good drops again. Holding the output-enable input low for at least a minimum time rewinds the bit pointer to the start of the stream, so the loader can reconfigure again without waiting for the power-on delay. A shorter low pulse leaves the pointer where it was. After the last stored bit has been taken, the output rests at 1 and a done flag is raised. The pointer does not wrap.

Top module: `cfg_stream_server`

## Requirements
- R1: While `rst_n` (power-good) is low, and in the first cycle after it rises, `data_oe` and `done` are 0 and `data_out` is 0.
- R2: After `rst_n` rises, `data_oe` stays 0 for `POR_CYC` system cycles even with `oe_in` high. Rising edges of `cfg_clk` during that time do not move the bit pointer, so bit 0 is the first bit shown once the delay ends.
- R3: Stream bit k is bit (k mod 8) of stored byte (k div 8), so each byte goes out least significant bit first. Each rising edge of `cfg_clk` moves the pointer by one bit, and the next bit shows on `data_out` within 3 system cycles of that edge.
- R4: When `oe_in` is held low for more than `OE_MIN_CYC` + 2 system cycles, the pointer returns to bit 0 and `done` clears.
- R5: An `oe_in` low pulse shorter than `OE_MIN_CYC` system cycles leaves the pointer unchanged. Rising edges of `cfg_clk` that arrive while `oe_in` is low do not move it.
- R6: `data_oe` is 0 while `oe_in` is low. Once the block is ready, `data_oe` becomes 1 within 3 system cycles after `oe_in` rises.
- R7: Once the power-on delay has elapsed, a rewind by `oe_in` does not apply the delay again. Service resumes within 3 cycles after `oe_in` returns high.
- R8: The edge that takes the last bit (index `STREAM_BITS`-1) sets `done` and drives `data_out` to 1. Further `cfg_clk` edges keep `done` at 1 and `data_out` at 1, and the pointer does not wrap.
- R9: `data_out` reads 0 whenever `data_oe` is 0.
- R10: A write on the load port (`load_we` high for one cycle) stores `load_byte` at byte index `load_addr`. It is visible on `data_out` from the next cycle when the pointer addresses that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Power-good; low means power lost; synchronous active-low reset |
| cfg_clk | input | 1 | Configuration clock from the loading device |
| oe_in | input | 1 | Output enable; a long low pulse rewinds the stream |
| load_we | input | 1 | Storage write strobe |
| load_addr | input | BYTE_AW | Byte index to write |
| load_byte | input | 8 | Byte to store |
| data_out | output | 1 | Served bitstream bit |
| data_oe | output | 1 | Drive enable for `data_out` (0 = released) |
| done | output | 1 | Whole stream has been consumed |

## Verification
A wrong pointer shows at once as a wrong bit on `data_out`. The bench compares every served bit against a stream it computes itself, so the error is caught at the first edge where it happens. A rewind that fires wrongly, or fails to fire, shows on the first bit after `oe_in` returns high. A pointer that wraps or stalls at the end shows as a `done` flag or idle level that is wrong within 3 cycles of the final edge. A wrong power-on timer shows as an enable that rises early or late, measured against the cycle count since power-good.

// File: rtl/cfgsrv_pkg.sv
// Shared definitions for the configuration bitstream server.
// Assumes nothing beyond a single system clock domain.
package cfgsrv_pkg;
    // Flops in each input synchronizer chain.
    localparam int unsigned SYNC_STAGES = 2;

    // Phases of the power-on timer.
    typedef enum logic {
        POR_WAIT = 1'b0,
        POR_DONE = 1'b1
    } por_phase_t;
endpackage

// File: rtl/cfgsrv_sync.sv
// Multi-bit synchronizer that also flags rising edges.
// Each bit passes through its own SYNC_STAGES-deep flop chain. A single
// extra flop per bit gives a one-cycle rise pulse.
// Assumes the inputs are slow compared with clk: a level must hold for
// at least two clk periods to be seen.
module cfgsrv_sync #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out,
    output logic [W-1:0] rise
);
    import cfgsrv_pkg::*;

    logic [W-1:0] prev;

    generate
        for (genvar b = 0; b < W; b++) begin : g_bit
            logic [SYNC_STAGES-1:0] chain;
            // Shift the raw input through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[SYNC_STAGES-2:0], async_in[b]};
            end
            assign sync_out[b] = chain[SYNC_STAGES-1];

            // A rise pulse lasts exactly one cycle.
            p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
                rise[b] |=> !rise[b]);
        end
    endgenerate

    // Keep the last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= sync_out;
    end

    assign rise = sync_out & ~prev;
endmodule

// File: rtl/cfgsrv_por.sv
// Power-on delay timer with a sticky ready flag.
// After rst_n rises it counts POR_CYC cycles and then raises ready. Ready
// stays high until power-good drops, so later rewinds never wait again.
module cfgsrv_por #(
    parameter int unsigned POR_CYC = 25_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready
);
    import cfgsrv_pkg::*;

    localparam int unsigned CW = $clog2(POR_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(POR_CYC - 1);

    por_phase_t      phase;
    logic [CW-1:0]   cnt;

    // Count out the power-on delay once, then latch the done phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= POR_WAIT;
            cnt   <= '0;
        end else if (phase == POR_WAIT) begin
            if (cnt == LAST) phase <= POR_DONE;
            else             cnt   <= cnt + 1'b1;
        end
    end

    assign ready = (phase == POR_DONE);

    // The ready flag is sticky until power is lost.
    p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);
    // Ready never rises before the count has reached its end.
    p_ready_late_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(cnt) == LAST));
endmodule

// File: rtl/cfgsrv_store.sv
// Byte-wide bitstream storage with one write port and a bit-level read.
// The read is combinational. Bit k is bit k[2:0] of byte k[..:3], so each
// byte is served LSB first. The array has no reset: its contents survive
// power-good loss in this model.
module cfgsrv_store #(
    parameter int unsigned STREAM_BITS = 8192
) (
    input  logic                                      clk,
    input  logic                                      we,
    input  logic [$clog2((STREAM_BITS+7)/8)-1:0]      waddr,
    input  logic [7:0]                                wdata,
    input  logic [$clog2((STREAM_BITS+7)/8)+2:0]      bit_addr,
    output logic                                      bit_out
);
    localparam int unsigned NBYTES  = (STREAM_BITS + 7) / 8;
    localparam int unsigned BYTE_AW = $clog2(NBYTES);

    logic [7:0] mem [NBYTES];

    // Store one byte per write strobe.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign bit_out = mem[bit_addr[BYTE_AW+2:3]][bit_addr[2:0]];
endmodule

// File: rtl/cfgsrv_ptr.sv
// Bit pointer with rewind-by-width detection and end-of-stream handling.
// The OE-low time is measured in system cycles. Once the low time reaches
// OE_MIN_CYC, the pointer is held at bit 0 and done is cleared. The
// pointer moves only on a synchronized config-clock rise while serving.
// It stops at the last bit and raises done instead of wrapping.
module cfgsrv_ptr #(
    parameter int unsigned STREAM_BITS = 8192,
    parameter int unsigned OE_MIN_CYC  = 13
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  oe_s,
    input  logic                                  step,
    output logic [$clog2((STREAM_BITS+7)/8)+2:0]  bit_addr,
    output logic                                  done
);
    localparam int unsigned BIT_AW = $clog2((STREAM_BITS + 7) / 8) + 3;
    localparam int unsigned LW     = $clog2(OE_MIN_CYC + 1);
    localparam logic [BIT_AW-1:0] LAST_BIT = BIT_AW'(STREAM_BITS - 1);
    localparam logic [LW-1:0]     LOW_MAX  = LW'(OE_MIN_CYC);

    logic [LW-1:0] low_cnt;
    logic          rewind;

    // Measure how long OE has been low, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!rst_n)               low_cnt <= '0;
        else if (oe_s)            low_cnt <= '0;
        else if (low_cnt != LOW_MAX) low_cnt <= low_cnt + 1'b1;
    end

    assign rewind = !oe_s && (low_cnt == LOW_MAX);

    // Rewind, advance or finish the bit pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_addr <= '0;
            done     <= 1'b0;
        end else if (rewind) begin
            bit_addr <= '0;
            done     <= 1'b0;
        end else if (step && !done) begin
            if (bit_addr == LAST_BIT) done     <= 1'b1;
            else                      bit_addr <= bit_addr + 1'b1;
        end
    end

    // Once done, the pointer stays done until a rewind.
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rewind) |=> (done && $stable(bit_addr)));
    // Without a step or a rewind the pointer does not move.
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !rewind) |=> $stable(bit_addr));
    // The pointer never runs past the last stored bit.
    p_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_addr <= LAST_BIT);
    // A rewind leaves the pointer at the start.
    p_rewind_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> (bit_addr == '0 && !done));
endmodule

// File: rtl/cfg_stream_server.sv
// Serial configuration bitstream server top level.
// Synchronizes the external config clock and OE and runs the power-on
// timer. Serves one stored bit per config-clock rise. data_out is forced
// to 0 while data_oe is low, and rests at 1 once the stream is done.
// Assumes clk is several times faster than cfg_clk (3 clk edges of
// latency from a cfg_clk rise to the new bit).
module cfg_stream_server #(
    parameter int unsigned STREAM_BITS = 8192,
    parameter int unsigned POR_CYC     = 25_000_000,
    parameter int unsigned OE_MIN_CYC  = 13,
    parameter int unsigned BYTE_AW     = $clog2((STREAM_BITS + 7) / 8)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_clk,
    input  logic               oe_in,
    input  logic               load_we,
    input  logic [BYTE_AW-1:0] load_addr,
    input  logic [7:0]         load_byte,
    output logic               data_out,
    output logic               data_oe,
    output logic               done
);
    localparam int unsigned BIT_AW = BYTE_AW + 3;

    logic [1:0]        s_lvl;
    logic [1:0]        s_rise;
    logic              ready;
    logic              serving;
    logic              step;
    logic [BIT_AW-1:0] bit_addr;
    logic              cur_bit;
    logic              done_i;

    cfgsrv_sync #(.W(2)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({oe_in, cfg_clk}),
        .sync_out (s_lvl),
        .rise     (s_rise)
    );

    cfgsrv_por #(.POR_CYC(POR_CYC)) u_por (
        .clk   (clk),
        .rst_n (rst_n),
        .ready (ready)
    );

    assign serving = ready && s_lvl[1];
    assign step    = serving && s_rise[0];

    cfgsrv_ptr #(.STREAM_BITS(STREAM_BITS), .OE_MIN_CYC(OE_MIN_CYC)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .oe_s     (s_lvl[1]),
        .step     (step),
        .bit_addr (bit_addr),
        .done     (done_i)
    );

    cfgsrv_store #(.STREAM_BITS(STREAM_BITS)) u_store (
        .clk      (clk),
        .we       (load_we),
        .waddr    (load_addr),
        .wdata    (load_byte),
        .bit_addr (bit_addr),
        .bit_out  (cur_bit)
    );

    assign data_oe  = serving;
    assign data_out = serving && (done_i || cur_bit);
    assign done     = done_i;

    // Nothing is served before the power-on delay has ended.
    p_quiet_por_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !data_oe);
    // Done can only rise on an accepted config-clock step.
    p_done_on_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(step));
endmodule

// File: tb/test_cfg_stream_server.sv
module test_cfg_stream_server;
    localparam int NBITS  = 40;
    localparam int NBYTES = 5;
    localparam int POR    = 60;
    localparam int OEMIN  = 13;
    localparam int BAW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_clk = 1'b0;
    logic oe_in = 1'b0;
    logic load_we = 1'b0;
    logic [BAW-1:0] load_addr = '0;
    logic [7:0] load_byte = '0;
    logic data_out, data_oe, done;

    int total = 0;
    int bad = 0;
    logic [7:0] ref_mem [NBYTES];

    always #4 clk = ~clk;

    cfg_stream_server #(
        .STREAM_BITS(NBITS), .POR_CYC(POR), .OE_MIN_CYC(OEMIN)
    ) i_cfg_stream_server (
        .clk(clk), .rst_n(rst_n), .cfg_clk(cfg_clk), .oe_in(oe_in),
        .load_we(load_we), .load_addr(load_addr), .load_byte(load_byte),
        .data_out(data_out), .data_oe(data_oe), .done(done)
    );

    function automatic logic exp_bit(int k);
        return ref_mem[k / 8][k % 8];
    endfunction

    task automatic chk(input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%b expected=%b", what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One config-clock period of 10 system cycles.
    task automatic cfg_edge();
        cfg_clk = 1'b1; cyc(5);
        cfg_clk = 1'b0; cyc(5);
    endtask

    task automatic t_load_and_reset();
        for (int i = 0; i < NBYTES; i++) begin
            ref_mem[i] = 8'(i * 8'h3B + 8'h6D);
            load_we = 1'b1; load_addr = BAW'(i); load_byte = ref_mem[i];
            cyc(1);
        end
        load_we = 1'b0;
        oe_in = 1'b1;
        cyc(3);
        chk(data_oe, 1'b0, "R1 data_oe in reset");
        chk(done, 1'b0, "R1 done in reset");
        chk(data_out, 1'b0, "R1 data_out in reset");
        rst_n = 1'b1;
        cyc(1);
        chk(data_oe, 1'b0, "R1 data_oe after release");
    endtask

    task automatic t_por();
        // Three config edges in the delay window must be ignored.
        for (int i = 0; i < 3; i++) cfg_edge();
        cyc(10);
        chk(data_oe, 1'b0, "R2 quiet during delay (R9 data_out)");
        chk(data_out, 1'b0, "R9 data_out released");
        cyc(25);
        chk(data_oe, 1'b1, "R2 served after delay");
        chk(data_out, exp_bit(0), "R2 first bit is bit 0");
    endtask

    task automatic t_stream(input int from, input int n);
        for (int k = from; k < from + n; k++) begin
            chk(data_out, exp_bit(k), $sformatf("R3 bit %0d", k));
            cfg_edge();
        end
    endtask

    task automatic t_short_pulse();
        oe_in = 1'b0; cyc(2);
        cfg_clk = 1'b1; cyc(3);
        chk(data_oe, 1'b0, "R6 data_oe low with oe low");
        chk(data_out, 1'b0, "R9 data_out 0 when released");
        cfg_clk = 1'b0; cyc(3);
        oe_in = 1'b1; cyc(4);
        chk(data_oe, 1'b1, "R6 enable back");
        chk(data_out, exp_bit(10), "R5 short pulse keeps pointer");
    endtask

    task automatic t_rewind(input string tag);
        oe_in = 1'b0; cyc(30);
        oe_in = 1'b1; cyc(4);
        chk(data_oe, 1'b1, {tag, " R7 no second delay"});
        chk(done, 1'b0, {tag, " R4 done cleared"});
        chk(data_out, exp_bit(0), {tag, " R4 back at bit 0"});
    endtask

    task automatic t_end();
        t_stream(0, NBITS);
        chk(done, 1'b1, "R8 done after last bit");
        chk(data_out, 1'b1, "R8 idle level 1");
        cfg_edge(); cfg_edge();
        chk(done, 1'b1, "R8 done holds");
        chk(data_out, 1'b1, "R8 no wrap");
    endtask

    task automatic t_reload();
        ref_mem[0] = ~ref_mem[0];
        load_we = 1'b1; load_addr = '0; load_byte = ref_mem[0];
        cyc(1);
        load_we = 1'b0;
        chk(data_out, exp_bit(0), "R10 new byte served");
        cfg_edge();
        chk(data_out, exp_bit(1), "R10 new byte bit 1");
    endtask

    initial begin
        cyc(2);
        t_load_and_reset();
        t_por();
        t_stream(0, 10);
        t_short_pulse();
        t_stream(10, 4);
        t_rewind("mid");
        t_end();
        t_rewind("end");
        t_reload();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule